// File: doc/BRIEF.md
# Occupancy-Driven Dimming Light Controller

This block turns a noisy motion-sensor line into a smoothly changing LED brightness. The raw sensor level is synchronised and passed through a settle window that restarts on every edge. The line is read only when the window runs out, so short glitches and contact bounce never reach the occupancy logic. An accepted change of occupancy restarts a hold timer. Becoming occupied requests full brightness at once. Becoming vacant only dims the light once the hold timer has run out.

Brightness does not switch. It moves toward its target by one unit per ramp interval and stops on the target. A PWM output turns the brightness into a duty cycle. A remote command port lets an outside messaging layer force the occupancy state or load a brightness target directly. An occupancy-change pulse tells that layer when to report. All timing counts pulses of a shared timebase tick, one tick nominally being 100 µs. With the default parameters this gives a 50 ms settle window, a 5 s hold, a 100 ms ramp step and a 10 ms PWM period.

Top module: `occ_dimmer_top`

## Requirements
- R1: A sensor level is taken only after the synchronised line has shown no edge for SETTLE_TICKS ticks. Any edge inside the window restarts it from the full count.
- R2: A settled sample equal to the current occupancy state has no effect: no event, no hold restart, no target change.
- R3: An accepted change to occupied sets the target to LEVEL_MAX (100), cancels any fade in progress, and pulses occ_evt for one cycle. occ_state is 1 from that same cycle.
- R4: An accepted change to vacant pulses occ_evt and clears occ_state. Brightness is held for HOLD_TICKS ticks. Every accepted change restarts that hold count.
- R5: When the hold count runs out while the state is vacant, the target becomes 0 and brightness fades down.
- R6: Brightness changes by exactly one unit every STEP_TICKS ticks toward the target, and stops when it equals the target.
- R7: A command with cmd_sel=0 loads cmd_arg as the new target, with values above LEVEL_MAX clamped to LEVEL_MAX. It restarts the step interval. Brightness never exceeds LEVEL_MAX.
- R8: A command with cmd_sel=1 applies cmd_arg[0] (1 = occupied) exactly as an accepted sensor change would, including the hold restart. The event is emitted only if the state actually changes.
- R9: Over any PWM period of LEVEL_MAX*UNIT_TICKS ticks with steady brightness, pwm_out is high for level*UNIT_TICKS ticks. It is always low at level 0 and always high at LEVEL_MAX.
- R10: Settle, hold, ramp and PWM counters advance only in cycles where tick is high. With tick low, brightness does not move.
- R11: Reset clears brightness, target, occupancy, pwm_out and occ_evt to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle per time unit |
| sensor_raw | input | 1 | Asynchronous motion-sensor level, 1 = motion |
| cmd_valid | input | 1 | Remote command strobe |
| cmd_sel | input | 1 | 0 = set brightness target, 1 = set occupancy |
| cmd_arg | input | 8 | Target level, or occupancy in bit 0 |
| pwm_out | output | 1 | LED drive |
| level | output | 8 | Current brightness, 0 to LEVEL_MAX |
| occ_state | output | 1 | Current occupancy, 1 = occupied |
| occ_evt | output | 1 | One-cycle pulse on every occupancy change |

## Verification
The hardest situations to reach are the ones where two timers overlap. One is a vacancy that arrives during a fade and must not stop the light early. Another is a return to occupancy in the middle of a fade, which must cancel it. A third is a burst of bounce, each edge of which restarts the settle window. The bench shrinks the settle, hold and step counts through parameters so these windows are a few cycles long. It toggles the sensor faster than the settle window, then watches for the single accepted change at the exact point where the window should expire. It raises the sensor again once the fade is under way, and it re-issues a vacant command while already vacant to show that the hold restart alone still leads to switch-off.

// File: rtl/dim_pkg.sv
package dim_pkg;

    localparam int LVL_W = 8;

    typedef enum logic {
        CMD_SET_LEVEL = 1'b0,
        CMD_SET_OCC   = 1'b1
    } cmd_kind_e;

    // settled sensor sample
    typedef struct packed {
        logic vld;
        logic lvl;
    } sample_t;

    // brightness target load request
    typedef struct packed {
        logic             vld;
        logic [LVL_W-1:0] val;
    } tgt_req_t;

    function automatic logic [LVL_W-1:0] clamp_level(input logic [LVL_W-1:0] v,
                                                     input logic [LVL_W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/dim_settle.sv
module dim_settle
    import dim_pkg::*;
#(
    parameter int SETTLE_TICKS = 500
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    raw,
    output sample_t samp
);
    localparam int CW = $clog2(SETTLE_TICKS + 1);
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE_TICKS);

    logic          s1, s2, s3;
    logic          armed;
    logic [CW-1:0] cnt;
    logic          edge_seen;

    assign edge_seen = s2 ^ s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            s3    <= 1'b0;
            armed <= 1'b0;
            cnt   <= '0;
            samp  <= '0;
        end else begin
            s1       <= raw;
            s2       <= s1;
            s3       <= s2;
            samp.vld <= 1'b0;
            if (edge_seen) begin
                cnt   <= RELOAD;
                armed <= 1'b1;
            end else if (tick && armed) begin
                if (cnt <= CW'(1)) begin
                    armed    <= 1'b0;
                    samp.vld <= 1'b1;
                    samp.lvl <= s2;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/dim_occ.sv
module dim_occ
    import dim_pkg::*;
#(
    parameter int HOLD_TICKS = 50000,
    parameter int LEVEL_MAX  = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  sample_t          samp,
    input  logic             cmd_valid,
    input  cmd_kind_e        cmd_sel,
    input  logic [LVL_W-1:0] cmd_arg,
    output logic             occ_state,
    output logic             occ_evt,
    output tgt_req_t         tgt
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0]    HOLD_RELOAD = HW'(HOLD_TICKS);
    localparam logic [LVL_W-1:0] FULL        = LVL_W'(LEVEL_MAX);

    logic [HW-1:0] hold_cnt;
    logic          req_vld;
    logic          req_lvl;
    logic          remote_occ;
    logic          remote_lvl;

    assign remote_occ = cmd_valid && (cmd_sel == CMD_SET_OCC);
    assign remote_lvl = cmd_valid && (cmd_sel == CMD_SET_LEVEL);

    always_comb begin
        req_vld = 1'b0;
        req_lvl = 1'b0;
        if (remote_occ) begin
            req_vld = 1'b1;
            req_lvl = cmd_arg[0];
        end else if (samp.vld && (samp.lvl != occ_state)) begin
            req_vld = 1'b1;
            req_lvl = samp.lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_state <= 1'b0;
            occ_evt   <= 1'b0;
            hold_cnt  <= '0;
            tgt       <= '0;
        end else begin
            occ_evt <= 1'b0;
            tgt.vld <= 1'b0;
            if (req_vld) begin
                hold_cnt <= HOLD_RELOAD;
                if (req_lvl != occ_state) begin
                    occ_state <= req_lvl;
                    occ_evt   <= 1'b1;
                end
                if (req_lvl) begin
                    tgt.vld <= 1'b1;
                    tgt.val <= FULL;
                end
            end else if (tick && (hold_cnt != '0)) begin
                hold_cnt <= hold_cnt - HW'(1);
                if ((hold_cnt == HW'(1)) && !occ_state) begin
                    tgt.vld <= 1'b1;
                    tgt.val <= '0;
                end
            end
            if (remote_lvl) begin
                tgt.vld <= 1'b1;
                tgt.val <= clamp_level(cmd_arg, FULL);
            end
        end
    end

endmodule

// File: rtl/dim_ramp.sv
module dim_ramp
    import dim_pkg::*;
#(
    parameter int STEP_TICKS = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tgt_req_t         tgt,
    output logic [LVL_W-1:0] level
);
    localparam int SW = $clog2(STEP_TICKS + 1);
    localparam logic [SW-1:0] STEP_RELOAD = SW'(STEP_TICKS);

    logic [LVL_W-1:0] target;
    logic [SW-1:0]    step_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            target   <= '0;
            level    <= '0;
            step_cnt <= STEP_RELOAD;
        end else if (tgt.vld) begin
            target   <= tgt.val;
            step_cnt <= STEP_RELOAD;
        end else if (tick && (level != target)) begin
            if (step_cnt <= SW'(1)) begin
                step_cnt <= STEP_RELOAD;
                level    <= (level < target) ? level + LVL_W'(1) : level - LVL_W'(1);
            end else begin
                step_cnt <= step_cnt - SW'(1);
            end
        end
    end

endmodule

// File: rtl/dim_pwm.sv
module dim_pwm
    import dim_pkg::*;
#(
    parameter int LEVEL_MAX  = 100,
    parameter int UNIT_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [LVL_W-1:0] level,
    output logic             pwm_out
);
    localparam int PERIOD = LEVEL_MAX * UNIT_TICKS;
    localparam int PW     = $clog2(PERIOD + 1);

    logic [PW-1:0] slot;
    logic [PW-1:0] high_len;

    generate
        if (UNIT_TICKS == 1) begin : g_unit
            assign high_len = PW'(level);
        end else begin : g_scaled
            assign high_len = PW'(level) * PW'(UNIT_TICKS);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            slot    <= '0;
            pwm_out <= 1'b0;
        end else begin
            pwm_out <= (slot < high_len);
            if (tick) begin
                slot <= (slot == PW'(PERIOD - 1)) ? '0 : slot + PW'(1);
            end
        end
    end

endmodule

// File: rtl/occ_dimmer_top.sv
module occ_dimmer_top
    import dim_pkg::*;
#(
    parameter int SETTLE_TICKS = 500,
    parameter int HOLD_TICKS   = 50000,
    parameter int STEP_TICKS   = 1000,
    parameter int LEVEL_MAX    = 100,
    parameter int UNIT_TICKS   = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       sensor_raw,
    input  logic       cmd_valid,
    input  logic       cmd_sel,
    input  logic [7:0] cmd_arg,
    output logic       pwm_out,
    output logic [7:0] level,
    output logic       occ_state,
    output logic       occ_evt
);
    sample_t   samp;
    tgt_req_t  tgt;
    cmd_kind_e kind;

    assign kind = cmd_kind_e'(cmd_sel);

    dim_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .raw (sensor_raw),
        .samp(samp)
    );

    dim_occ #(.HOLD_TICKS(HOLD_TICKS), .LEVEL_MAX(LEVEL_MAX)) u_occ (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .samp     (samp),
        .cmd_valid(cmd_valid),
        .cmd_sel  (kind),
        .cmd_arg  (cmd_arg),
        .occ_state(occ_state),
        .occ_evt  (occ_evt),
        .tgt      (tgt)
    );

    dim_ramp #(.STEP_TICKS(STEP_TICKS)) u_ramp (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .tgt  (tgt),
        .level(level)
    );

    dim_pwm #(.LEVEL_MAX(LEVEL_MAX), .UNIT_TICKS(UNIT_TICKS)) u_pwm (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .level  (level),
        .pwm_out(pwm_out)
    );

endmodule

// File: rtl/occ_dimmer_chk.sv
module occ_dimmer_chk #(
    parameter int LEVEL_MAX = 100
) (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       pwm_out,
    input logic [7:0] level,
    input logic       occ_state,
    input logic       occ_evt
);
    // R6: brightness moves by one unit at most per change
    p_unit_step_r6: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |->
            ((level == $past(level) + 8'd1) || (level + 8'd1 == $past(level))));

    // R7: brightness stays inside its range
    p_level_range_r7: assert property (@(posedge clk) disable iff (rst)
        level <= 8'(LEVEL_MAX));

    // R3: an event always marks a real change of occupancy
    p_evt_change_r3: assert property (@(posedge clk) disable iff (rst)
        occ_evt |-> (occ_state != $past(occ_state)));

    // R10: nothing moves without a tick
    p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(level));

    // R9: dark light never pulses
    p_pwm_dark_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(level) == 8'd0) |-> !pwm_out);

    // R9: full light never drops
    p_pwm_full_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(level) == 8'(LEVEL_MAX)) |-> pwm_out);

endmodule

bind occ_dimmer_top occ_dimmer_chk #(.LEVEL_MAX(LEVEL_MAX)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .pwm_out  (pwm_out),
    .level    (level),
    .occ_state(occ_state),
    .occ_evt  (occ_evt)
);

// File: tb/sim_occ_dimmer_top.sv
module sim_occ_dimmer_top;

    localparam int SETTLE = 4;
    localparam int HOLD   = 20;
    localparam int STEP   = 3;
    localparam int LMAX   = 100;

    typedef struct packed {
        logic        sel;
        logic [7:0]  arg;
        logic [15:0] wait_cyc;
        logic [7:0]  exp_level;
        logic        exp_occ;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd20,  16'd100, 8'd20,  1'b0},  // R6 ramp up
        '{1'b0, 8'd200, 16'd300, 8'd100, 1'b0},  // R7 clamp
        '{1'b0, 8'd0,   16'd350, 8'd0,   1'b0},  // R6 ramp down
        '{1'b1, 8'd1,   16'd350, 8'd100, 1'b1},  // R8 remote occupied
        '{1'b0, 8'd37,  16'd250, 8'd37,  1'b1},  // R7 remote level
        '{1'b1, 8'd0,   16'd200, 8'd0,   1'b0}   // R8 remote vacant
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       sensor_raw = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_sel = 1'b0;
    logic [7:0] cmd_arg = '0;
    logic       pwm_out;
    logic [7:0] level;
    logic       occ_state;
    logic       occ_evt;

    int checks = 0;
    int fails  = 0;
    int evt_cnt = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && occ_evt) evt_cnt <= evt_cnt + 1;
    end

    occ_dimmer_top #(
        .SETTLE_TICKS(SETTLE), .HOLD_TICKS(HOLD), .STEP_TICKS(STEP),
        .LEVEL_MAX(LMAX), .UNIT_TICKS(1)
    ) u0 (
        .clk(clk), .rst(rst), .tick(tick), .sensor_raw(sensor_raw),
        .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .cmd_arg(cmd_arg),
        .pwm_out(pwm_out), .level(level), .occ_state(occ_state), .occ_evt(occ_evt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_true(input string tag, input bit ok, input int act);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected condition true", tag, act);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic sel, input logic [7:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_sel   = sel;
        cmd_arg   = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pwm_highs(output int n);
        n = 0;
        for (int i = 0; i < LMAX; i++) begin
            @(negedge clk);
            if (pwm_out) n++;
        end
    endtask

    task automatic wait_level_change(output int at);
        logic [7:0] start;
        start = level;
        at = -1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (level != start) begin
                at = cyc;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int e0, n, t0, t1;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(1);
        // R11 reset state
        chk("R11 level", int'(level), 0);
        chk("R11 pwm", int'(pwm_out), 0);
        chk("R11 occ", int'(occ_state), 0);
        chk("R11 evt", evt_cnt, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            send(VECS[v].sel, VECS[v].arg);
            wait_cyc(int'(VECS[v].wait_cyc));
            chk($sformatf("R7/R8 vec%0d level", v), int'(level), int'(VECS[v].exp_level));
            chk($sformatf("R8 vec%0d occ", v), int'(occ_state), int'(VECS[v].exp_occ));
        end
        chk("R8 events from table", evt_cnt, 2);

        // R9 duty
        send(1'b0, 8'd30);
        wait_cyc(150);
        pwm_highs(n);
        chk("R9 duty 30", n, 30);
        send(1'b0, 8'd100);
        wait_cyc(250);
        pwm_highs(n);
        chk("R9 duty 100", n, 100);
        send(1'b0, 8'd0);
        wait_cyc(350);
        pwm_highs(n);
        chk("R9 duty 0", n, 0);

        // R10 tick gating
        tick = 1'b0;
        send(1'b0, 8'd40);
        wait_cyc(50);
        chk("R10 frozen level", int'(level), 0);
        tick = 1'b1;
        wait_cyc(150);
        chk("R10 resumes", int'(level), 40);

        // R6 step spacing
        send(1'b0, 8'd50);
        wait_level_change(t0);
        wait_level_change(t1);
        chk("R6 step spacing", t1 - t0, STEP);
        wait_cyc(60);
        chk("R6 stops at target", int'(level), 50);
        send(1'b0, 8'd0);
        wait_cyc(200);

        // R2 glitch shorter than window
        e0 = evt_cnt;
        sensor_raw = 1'b1;
        wait_cyc(2);
        sensor_raw = 1'b0;
        wait_cyc(30);
        chk("R2 glitch occ", int'(occ_state), 0);
        chk("R2 glitch evt", evt_cnt - e0, 0);
        chk("R2 glitch level", int'(level), 0);

        // R1 bounce restarts window
        for (int k = 0; k < 5; k++) begin
            sensor_raw = ~sensor_raw;
            wait_cyc(2);
        end
        sensor_raw = 1'b1;
        wait_cyc(4);
        chk("R1 not yet accepted", int'(occ_state), 0);
        wait_cyc(8);
        chk("R1 accepted", int'(occ_state), 1);
        chk("R3 one event", evt_cnt - e0, 1);
        wait_cyc(320);
        chk("R3 full level", int'(level), 100);

        // R4 hold, R5 fade
        sensor_raw = 1'b0;
        wait_cyc(15);
        chk("R4 vacant state", int'(occ_state), 0);
        chk("R4 held level", int'(level), 100);
        wait_cyc(45);
        chk_true("R5 fading", level < 8'd100, int'(level));

        // R3 re-occupy cancels fade
        for (int i = 0; i < 100 && level > 8'd90; i++) wait_cyc(1);
        sensor_raw = 1'b1;
        wait_cyc(350);
        chk("R3 fade cancelled", int'(level), 100);
        chk("R3 occ again", int'(occ_state), 1);

        // R8 remote occupancy
        e0 = evt_cnt;
        send(1'b1, 8'd1);
        wait_cyc(5);
        chk("R8 same state no event", evt_cnt - e0, 0);
        send(1'b1, 8'd0);
        wait_cyc(10);
        chk("R8 vacant event", evt_cnt - e0, 1);
        chk("R8 hold keeps level", int'(level), 100);
        wait_cyc(400);
        chk("R5 faded out", int'(level), 0);

        // R4 hold restart while vacant leads to switch-off
        send(1'b0, 8'd60);
        wait_cyc(200);
        chk("R7 level 60", int'(level), 60);
        e0 = evt_cnt;
        send(1'b1, 8'd0);
        wait_cyc(15);
        chk("R4 restart held", int'(level), 60);
        chk("R4 restart no event", evt_cnt - e0, 0);
        wait_cyc(40);
        chk_true("R4 off after hold", level < 8'd60, int'(level));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule